// File: doc/BRIEF.md
# Memory Address and Data Staging Unit

This block sits between a processor's internal data bus and an external memory bus. It keeps two registers. The address register is loaded from the internal bus, and it drives the external address lines at all times. The data register can be loaded from either bus and can drive either bus. Each of those four connections has its own enable, so the control unit chooses the data path one step at a time.

Memory answers a read or a write after a variable number of cycles. It signals the answer with a completion input. The control unit pulses a read or write strobe for one cycle, and the block keeps that request asserted toward memory until completion is seen. When the control unit raises its wait input, the block returns a stall until completion arrives. The stall is the only back-pressure the block exerts. A control step must not advance while the stall is high. No stall appears in a cycle where completion is already present.

A typical read uses three steps. First, load the address and issue the read together. Second, hold the external-capture enable together with the wait input. Third, drive the data register onto the internal bus. A write loads the address, then loads data from the internal bus, then drives the external data lines with the wait input raised.

Top module: `memxfer_unit`

## Requirements
- R1: While reset is active, the address and data registers are zero, and both memory request outputs are low.
- R2: At a clock edge with `addr_load` high, the address register takes the low `ADDR_W` bits of `ibus_in`. Otherwise it keeps its value. `mem_addr` always shows the register.
- R3: At a clock edge with `dat_load_int` high, the data register takes `ibus_in`, unless R4 applies in the same cycle.
- R4: At a clock edge where `dat_load_ext` and `mem_done` are both high, the data register takes `mem_rdata`. This takes priority over R3. When `dat_load_ext` is high without `mem_done`, the register does not change.
- R5: `ibus_out` always shows the data register. `ibus_oe` equals `dat_drive_int` in the same cycle.
- R6: `mem_wdata` always shows the data register. `mem_wdata_oe` equals `dat_drive_ext` in the same cycle.
- R7: `mem_rd` is high in every cycle with `rd_issue` high. It stays high in each later cycle up to and including the first cycle with `mem_done` high. It is low in the cycle after that cycle, unless `rd_issue` is high again.
- R8: `mem_wr` follows the same rule as R7, driven by `wr_issue` instead of `rd_issue`.
- R9: `stall` is high exactly in cycles where `wait_done` is high and `mem_done` is low. No stall occurs if `mem_done` is already high when `wait_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ibus_in | input | DATA_W | Value present on the internal bus |
| addr_load | input | 1 | Load the address register from the internal bus |
| dat_load_int | input | 1 | Load the data register from the internal bus |
| dat_load_ext | input | 1 | Capture memory read data into the data register when completion is present |
| dat_drive_int | input | 1 | Data register drives the internal bus |
| dat_drive_ext | input | 1 | Data register drives the external data lines |
| rd_issue | input | 1 | Start a memory read |
| wr_issue | input | 1 | Start a memory write |
| wait_done | input | 1 | The control step waits for memory completion |
| mem_done | input | 1 | Memory completion |
| mem_rdata | input | DATA_W | External read data |
| ibus_out | output | DATA_W | Data register value toward the internal bus |
| ibus_oe | output | 1 | Internal bus drive enable |
| mem_addr | output | ADDR_W | External address lines |
| mem_wdata | output | DATA_W | Data register value toward the external bus |
| mem_wdata_oe | output | 1 | External data drive enable |
| mem_rd | output | 1 | Read request to memory |
| mem_wr | output | 1 | Write request to memory |
| stall | output | 1 | Hold the current control step |

## Verification
A corrupted address or data register appears at `mem_addr`, `ibus_out` and `mem_wdata` in the cycle right after the faulty edge, because these outputs show the registers with no logic in between. A request flag that is cleared too early or set too late appears at `mem_rd` or `mem_wr` in the first cycle after issue or after completion. A stall computed wrongly is visible in the same cycle as its inputs. The bench compares every output in every cycle, so each of these faults is seen within one clock.

// File: rtl/memxfer_pkg.sv
package memxfer_pkg;

  typedef enum logic [1:0] {
    MDR_HOLD     = 2'd0,
    MDR_FROM_INT = 2'd1,
    MDR_FROM_EXT = 2'd2
  } mdr_src_e;

  // External capture with completion outranks an internal load.
  function automatic mdr_src_e pick_mdr_src(input logic ld_int,
                                            input logic ld_ext,
                                            input logic done);
    if (ld_ext && done) return MDR_FROM_EXT;
    if (ld_int)         return MDR_FROM_INT;
    return MDR_HOLD;
  endfunction

endpackage

// File: rtl/mxu_addr_reg.sv
module mxu_addr_reg #(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BUS_W-1:0]  bus_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= bus_i[ADDR_W-1:0];
  end

  assign addr_o = addr_q;

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(addr_o));

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(bus_i[ADDR_W-1:0])));

endmodule

// File: rtl/mxu_data_reg.sv
module mxu_data_reg
  import memxfer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_int_i,
  input  logic              ld_ext_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] int_i,
  input  logic [DATA_W-1:0] ext_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] data_q;
  mdr_src_e          src;

  always_comb src = pick_mdr_src(ld_int_i, ld_ext_i, done_i);

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= '0;
    else begin
      unique case (src)
        MDR_FROM_EXT: data_q <= ext_i;
        MDR_FROM_INT: data_q <= int_i;
        default:      data_q <= data_q;
      endcase
    end
  end

  assign data_o = data_q;

  assert_ext_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ext_i && done_i) |=> (data_o == $past(ext_i)));

  assert_int_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_int_i && !(ld_ext_i && done_i)) |=> (data_o == $past(int_i)));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_int_i && !(ld_ext_i && done_i)) |=> $stable(data_o));

endmodule

// File: rtl/mxu_req_track.sv
module mxu_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic done_i,
  output logic req_o
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (issue_i || pend_q) && !done_i;
  end

  assign req_o = issue_i || pend_q;

  assert_req_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !done_i) |=> req_o);

  assert_req_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (req_o == issue_i));

endmodule

// File: rtl/memxfer_unit.sv
module memxfer_unit
  import memxfer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ibus_in,
  input  logic              addr_load,
  input  logic              dat_load_int,
  input  logic              dat_load_ext,
  input  logic              dat_drive_int,
  input  logic              dat_drive_ext,
  input  logic              rd_issue,
  input  logic              wr_issue,
  input  logic              wait_done,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ibus_out,
  output logic              ibus_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              stall
);

  localparam int NUM_REQ = 2;  // index 0: read, index 1: write

  logic [DATA_W-1:0]  mdr;
  logic [NUM_REQ-1:0] issue_vec;
  logic [NUM_REQ-1:0] req_vec;

  mxu_addr_reg #(.ADDR_W(ADDR_W), .BUS_W(DATA_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (addr_load),
    .bus_i  (ibus_in),
    .addr_o (mem_addr)
  );

  mxu_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_int_i (dat_load_int),
    .ld_ext_i (dat_load_ext),
    .done_i   (mem_done),
    .int_i    (ibus_in),
    .ext_i    (mem_rdata),
    .data_o   (mdr)
  );

  assign issue_vec = {wr_issue, rd_issue};

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    mxu_req_track u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue_i (issue_vec[g]),
      .done_i  (mem_done),
      .req_o   (req_vec[g])
    );
  end

  assign mem_rd       = req_vec[0];
  assign mem_wr       = req_vec[1];
  assign ibus_out     = mdr;
  assign ibus_oe      = dat_drive_int;
  assign mem_wdata    = mdr;
  assign mem_wdata_oe = dat_drive_ext;
  assign stall        = wait_done && !mem_done;

  assert_stall_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && mem_done) |-> 1'b0);

  assert_stall_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_done && mem_done) |-> !stall);

endmodule

// File: tb/memxfer_unit_tb.sv
`timescale 1ns/1ps
module memxfer_unit_tb_top;

  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] ibus_in = '0, mem_rdata = '0;
  logic addr_load = 0, dat_load_int = 0, dat_load_ext = 0, dat_drive_int = 0;
  logic dat_drive_ext = 0, rd_issue = 0, wr_issue = 0, wait_done = 0, mem_done = 0;
  logic [DW-1:0] ibus_out, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic ibus_oe, mem_wdata_oe, mem_rd, mem_wr, stall;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference state
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  bit m_rp = 0, m_wp = 0;

  always #2 clk = ~clk;

  memxfer_unit #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ibus_in(ibus_in), .addr_load(addr_load),
    .dat_load_int(dat_load_int), .dat_load_ext(dat_load_ext),
    .dat_drive_int(dat_drive_int), .dat_drive_ext(dat_drive_ext),
    .rd_issue(rd_issue), .wr_issue(wr_issue), .wait_done(wait_done),
    .mem_done(mem_done), .mem_rdata(mem_rdata), .ibus_out(ibus_out),
    .ibus_oe(ibus_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rd(mem_rd), .mem_wr(mem_wr), .stall(stall)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = '0; m_data = '0; m_rp = 0; m_wp = 0;
    end else begin
      if (addr_load) m_addr = ibus_in[AW-1:0];
      if (dat_load_ext && mem_done) m_data = mem_rdata;
      else if (dat_load_int)        m_data = ibus_in;
      m_rp = (rd_issue || m_rp) && !mem_done;
      m_wp = (wr_issue || m_wp) && !mem_done;
    end
  end

  task automatic cmp(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("R2 mem_addr", mem_addr, m_addr);
    cmp("R3/R4 ibus_out (R5)", ibus_out, m_data);
    cmp("R5 ibus_oe", ibus_oe, dat_drive_int);
    cmp("R6 mem_wdata", mem_wdata, m_data);
    cmp("R6 mem_wdata_oe", mem_wdata_oe, dat_drive_ext);
    cmp("R7 mem_rd", mem_rd, rd_issue || m_rp);
    cmp("R8 mem_wr", mem_wr, wr_issue || m_wp);
    cmp("R9 stall", stall, wait_done && !mem_done);
  endtask

  // Set inputs at a falling edge, check shortly after, then move to the next falling edge.
  task automatic step(input logic [DW-1:0] bus, input logic la, input logic li,
                      input logic le, input logic di, input logic de,
                      input logic rd, input logic wr, input logic wt,
                      input logic dn, input logic [DW-1:0] rdat);
    ibus_in = bus; addr_load = la; dat_load_int = li; dat_load_ext = le;
    dat_drive_int = di; dat_drive_ext = de; rd_issue = rd; wr_issue = wr;
    wait_done = wt; mem_done = dn; mem_rdata = rdat;
    #1 check_all();
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    step('0,0,0,0,0,0,0,0,0,0,'0);
    step('0,0,0,0,0,0,0,0,0,0,'0);
    cmp("R1 reset addr", mem_addr, 0);
    cmp("R1 reset data", ibus_out, 0);
    cmp("R1 reset rd/wr", {mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    // R2/R7 read: address and request together, then a three-cycle wait with capture enabled
    step(16'hFA12,1,0,0,0,0,1,0,0,0,'0);
    step('0,0,0,1,0,0,0,0,1,0,16'h1111);      // R4: no capture without completion
    step('0,0,0,1,0,0,0,0,1,0,16'h2222);
    step('0,0,0,1,0,0,0,0,1,1,16'hBEEF);      // completion: capture, no stall
    step('0,0,0,0,1,0,0,0,0,0,'0);            // R7: mem_rd dropped
    cmp("R4 captured read data", ibus_out, 16'hBEEF);
    cmp("R2 truncated address", mem_addr, 12'hA12);
    // R8 write sequence
    step(16'h0345,1,0,0,0,0,0,1,0,0,'0);
    step(16'hC0DE,0,1,0,0,0,0,1,0,0,'0);
    step('0,0,0,0,0,1,0,0,1,0,'0);
    step('0,0,0,0,0,1,0,0,1,0,'0);
    step('0,0,0,0,0,1,0,0,1,1,'0);
    step('0,0,0,0,0,0,0,0,0,0,'0);
    cmp("R6 write data held", mem_wdata, 16'hC0DE);
    // R9: completion already present when waiting starts
    step('0,0,0,0,0,0,1,0,1,1,'0);
    step('0,0,0,0,0,0,0,0,0,0,'0);
    // R4 priority over R3
    step(16'h1234,0,1,1,0,0,0,0,0,1,16'h5678);
    step('0,0,0,0,0,0,0,0,0,0,'0);
    cmp("R4 external wins", ibus_out, 16'h5678);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(DW'($urandom), r[0] & r[1], r[2] & r[3], r[4], r[5], r[6],
           r[7] & r[8] & r[9], r[10] & r[11] & r[12], r[13],
           r[14] & r[15], DW'($urandom));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule